// File: doc/BRIEF.md
# Serial Audio Link Frame Controller

This block is the controller end of a time-multiplexed serial audio link. It runs on the link bit clock and divides that clock by the frame length to make the frame marker `sync`. Each frame opens with a rising edge of `sync`. On the outbound line `sdo` it sends a 16-bit tag slot followed by twelve 20-bit data slots, taken from parallel inputs that are captured once per frame. On the inbound line `sdi` it collects the same 256-bit structure into parallel registers.

The host side presents the next frame's tag and slot words on `tx_tag` and `tx_slots` at any time before the frame begins. It reads the previous inbound frame on `rx_tag`, `rx_slots` and `codec_ready` after `frame_done` pulses. A codec-ready flag carried in the inbound tag tells the host that the codec's control registers are usable. The active-low `rst_n` acts as the link reset and silences the line at once.

A three-state sequencer drives the frame. `ST_IDLE` is the state held during link reset. `ST_TAG` covers bit positions 0 to 15 and `ST_DATA` covers positions 16 to 255. The transitions are:
- *start* (`ST_IDLE`→`ST_TAG`) on the first clock after reset is released.
- *tag_end* (`ST_TAG`→`ST_DATA`) after position 15.
- *wrap* (`ST_DATA`→`ST_TAG`) after position 255.
- *hold* (staying in the current state) on every other clock.

Top module: `serial_link_ctrl`

## Requirements
- R1: While `rst_n` is low, `sync`, `sdo`, `frame_start`, `frame_done`, `codec_ready`, `rx_tag` and `rx_slots` are all 0, and they drop to 0 as soon as `rst_n` falls, without waiting for a clock.
- R2: The first rising clock edge after `rst_n` goes high starts a frame. `sync` is then high for exactly 16 clocks and low for 240, which repeats every 256 clocks.
- R3: `frame_start` is high for exactly one clock, the clock in which `sync` first goes high (frame bit 0). It appears once per frame.
- R4: In frame bit k (k = 0..255), `sdo` carries bit k of the outbound frame, most significant bit first. The outbound frame is `{tx_tag, tx_slots}`, with slot 1 in `tx_slots[239:220]` and slot 12 in `tx_slots[19:0]`.
- R5: `tx_tag` and `tx_slots` are sampled only at the clock edge that starts a frame. Changing them inside a frame has no effect on `sdo` until the next frame.
- R6: The bit the codec places on `sdi` during frame bit k is captured at the rising edge that ends that bit. The inbound frame is `{rx_tag, rx_slots}` with the same slot order as R4. The outputs update together at the edge that ends bit 255 and then hold for the whole following frame.
- R7: `frame_done` is a one-clock pulse in the clock after inbound bit 255 has been captured. That clock is bit 0 of the next frame.
- R8: `codec_ready` equals the most significant bit of the last complete inbound tag slot, and it changes only together with `frame_done`.
- R9: A link reset in the middle of a frame abandons that frame and clears the partial inbound capture. The frame after release begins with a full 16-bit tag period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst_n | input | 1 | Active-low link reset, asynchronous |
| sdi | input | 1 | Inbound serial data from the codec |
| tx_tag | input | 16 | Outbound tag slot for the next frame |
| tx_slots | input | 240 | Twelve outbound 20-bit slots, slot 1 in the top bits |
| sync | output | 1 | Frame marker, high during the tag slot |
| sdo | output | 1 | Outbound serial data |
| frame_start | output | 1 | Pulse during frame bit 0 |
| frame_done | output | 1 | Pulse when a full inbound frame is available |
| rx_tag | output | 16 | Last complete inbound tag slot |
| rx_slots | output | 240 | Last complete inbound data slots, slot 1 in the top bits |
| codec_ready | output | 1 | Codec-ready flag from the inbound tag |

## Verification
A sequencer that has strayed from the correct state or bit count shows up on `sync` within one frame. The tag period comes out at a length other than 16, or the gap between rising edges differs from 256. Both are caught at the next falling or rising edge of `sync`. A shifter that is misaligned by one position corrupts `sdo` in the first bit of the frame that differs, and it shifts every field of `rx_slots` when `frame_done` pulses. A capture register that updates at the wrong moment changes `rx_tag` or `codec_ready` while `frame_done` is low, which is visible in that same clock.

// File: rtl/link_pkg.sv
package link_pkg;
    localparam int TAG_BITS  = 16;
    localparam int SLOT_BITS = 20;
    localparam int SLOT_NUM  = 12;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_DATA = 2'd2
    } seq_state_t;
endpackage

// File: rtl/frame_seq.sv
module frame_seq
    import link_pkg::*;
#(
    parameter int TAG_W     = TAG_BITS,
    parameter int FRAME_LEN = TAG_BITS + SLOT_NUM * SLOT_BITS
) (
    input  logic clk,
    input  logic rst_n,
    output logic sync,
    output logic running,
    output logic load_next,
    output logic first_bit,
    output logic last_bit
);
    localparam int CNT_W = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0] TAG_LAST   = CNT_W'(TAG_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_LEN - 1);

    seq_state_t       state, state_nxt;
    logic [CNT_W-1:0] pos, pos_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pos   <= '0;
        end else begin
            state <= state_nxt;
            pos   <= pos_nxt;
        end
    end

    // transitions: start, tag_end, wrap, hold
    always_comb begin
        state_nxt = state;
        pos_nxt   = pos + CNT_W'(1);
        unique case (state)
            ST_IDLE: begin
                state_nxt = ST_TAG;
                pos_nxt   = '0;
            end
            ST_TAG: begin
                if (pos == TAG_LAST) state_nxt = ST_DATA;
            end
            ST_DATA: begin
                if (pos == FRAME_LAST) begin
                    state_nxt = ST_TAG;
                    pos_nxt   = '0;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
                pos_nxt   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        sync      = (state == ST_TAG);
        running   = (state != ST_IDLE);
        first_bit = (state == ST_TAG) && (pos == '0);
        last_bit  = (state == ST_DATA) && (pos == FRAME_LAST);
        load_next = (state == ST_IDLE) || last_bit;
    end
endmodule

// File: rtl/tx_shift.sv
module tx_shift #(
    parameter int FRAME_LEN = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 running,
    input  logic [FRAME_LEN-1:0] frame_in,
    output logic                 sdo
);
    logic [FRAME_LEN-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= frame_in;
        end else if (running) begin
            sh <= {sh[FRAME_LEN-2:0], 1'b0};
        end
    end

    assign sdo = running & sh[FRAME_LEN-1];
endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
    parameter int FRAME_LEN = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sdi,
    input  logic                 running,
    input  logic                 last_bit,
    output logic [FRAME_LEN-1:0] frame_out,
    output logic                 done
);
    logic [FRAME_LEN-2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            frame_out <= '0;
            done      <= 1'b0;
        end else begin
            if (running) sh <= {sh[FRAME_LEN-3:0], sdi};
            if (last_bit) frame_out <= {sh, sdi};
            done <= last_bit;
        end
    end
endmodule

// File: rtl/serial_link_ctrl.sv
module serial_link_ctrl
    import link_pkg::*;
#(
    parameter int TAG_W    = TAG_BITS,
    parameter int SLOT_W   = SLOT_BITS,
    parameter int SLOT_CNT = SLOT_NUM
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sdi,
    input  logic [TAG_W-1:0]             tx_tag,
    input  logic [SLOT_CNT*SLOT_W-1:0]   tx_slots,
    output logic                         sync,
    output logic                         sdo,
    output logic                         frame_start,
    output logic                         frame_done,
    output logic [TAG_W-1:0]             rx_tag,
    output logic [SLOT_CNT*SLOT_W-1:0]   rx_slots,
    output logic                         codec_ready
);
    localparam int DATA_W    = SLOT_CNT * SLOT_W;
    localparam int FRAME_LEN = TAG_W + DATA_W;

    logic                 running, load_next, last_bit;
    logic [FRAME_LEN-1:0] rx_frame;

    frame_seq #(.TAG_W(TAG_W), .FRAME_LEN(FRAME_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync      (sync),
        .running   (running),
        .load_next (load_next),
        .first_bit (frame_start),
        .last_bit  (last_bit)
    );

    tx_shift #(.FRAME_LEN(FRAME_LEN)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_next),
        .running  (running),
        .frame_in ({tx_tag, tx_slots}),
        .sdo      (sdo)
    );

    rx_capture #(.FRAME_LEN(FRAME_LEN)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (sdi),
        .running   (running),
        .last_bit  (last_bit),
        .frame_out (rx_frame),
        .done      (frame_done)
    );

    assign rx_tag      = rx_frame[FRAME_LEN-1 -: TAG_W];
    assign rx_slots    = rx_frame[DATA_W-1:0];
    assign codec_ready = rx_frame[FRAME_LEN-1];
endmodule

// File: rtl/link_frame_chk.sv
module link_frame_chk #(
    parameter int TAG_W     = 16,
    parameter int FRAME_LEN = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync,
    input logic             sdo,
    input logic             frame_start,
    input logic             frame_done,
    input logic [TAG_W-1:0] rx_tag,
    input logic             codec_ready
);
    int   hi_run;
    int   since_rise;
    logic seen_rise;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run     <= 0;
            since_rise <= 0;
            seen_rise  <= 1'b0;
            sync_q     <= 1'b0;
        end else begin
            sync_q <= sync;
            hi_run <= sync ? hi_run + 1 : 0;
            if (sync && !sync_q) begin
                since_rise <= 1;
                seen_rise  <= 1'b1;
            end else begin
                since_rise <= since_rise + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!sync && !sdo && !frame_done && !codec_ready && !frame_start)
                else $error("link not quiet during reset");
        end
    end

    assert_tag_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync) |-> (hi_run == TAG_W))
        else $error("tag period length wrong");

    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !sync_q && seen_rise) |-> (since_rise == FRAME_LEN))
        else $error("frame period wrong");

    assert_start_at_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> frame_start)
        else $error("frame_start missing at sync rise");

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start)
        else $error("frame_start longer than one clock");

    assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(rx_tag))
        else $error("rx_tag changed outside frame_done");

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done)
        else $error("frame_done longer than one clock");

    assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> $stable(codec_ready))
        else $error("codec_ready changed outside frame_done");
endmodule

bind serial_link_ctrl link_frame_chk #(.TAG_W(TAG_W), .FRAME_LEN(FRAME_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync        (sync),
    .sdo         (sdo),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .rx_tag      (rx_tag),
    .codec_ready (codec_ready)
);

// File: tb/serial_link_ctrl_test.sv
module serial_link_ctrl_test;
    import link_pkg::*;

    localparam int TAG_W   = TAG_BITS;
    localparam int SLOT_W  = SLOT_BITS;
    localparam int NSLOT   = SLOT_NUM;
    localparam int DATA_W  = NSLOT * SLOT_W;
    localparam int FRAME_W = TAG_W + DATA_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sdi = 1'b0;
    logic [TAG_W-1:0]   tx_tag = '0;
    logic [DATA_W-1:0]  tx_slots = '0;
    logic               sync, sdo, frame_start, frame_done, codec_ready;
    logic [TAG_W-1:0]   rx_tag;
    logic [DATA_W-1:0]  rx_slots;

    int total = 0;
    int bad = 0;
    logic [FRAME_W-1:0] prev_rx = '0;

    always #2 clk = ~clk;

    serial_link_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .tx_tag(tx_tag), .tx_slots(tx_slots),
        .sync(sync), .sdo(sdo), .frame_start(frame_start), .frame_done(frame_done),
        .rx_tag(rx_tag), .rx_slots(rx_slots), .codec_ready(codec_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [FRAME_W-1:0] act, input logic [FRAME_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] make_slots(input int seed);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < NSLOT; i++)
            v[(NSLOT-i)*SLOT_W-1 -: SLOT_W] = SLOT_W'((seed + 1) * 40503 + i * 9973 + (i << seed));
        return v;
    endfunction

    // Precondition: at a falling edge inside frame bit 0.
    task automatic run_frame(input logic [FRAME_W-1:0] exp_tx, input logic [FRAME_W-1:0] drv_rx,
                             input logic [TAG_W-1:0] nx_tag, input logic [DATA_W-1:0] nx_slots,
                             input string name);
        int sdo_err = 0, sync_err = 0, start_err = 0, hold_err = 0;
        for (int k = 0; k < FRAME_W; k++) begin
            if (sdo !== exp_tx[FRAME_W-1-k]) sdo_err++;
            if (sync !== (k < TAG_W)) sync_err++;
            if (frame_start !== (k == 0)) start_err++;
            if (k > 0 && ({rx_tag, rx_slots} !== prev_rx || codec_ready !== prev_rx[FRAME_W-1]
                          || frame_done !== 1'b0)) hold_err++;
            sdi = drv_rx[FRAME_W-1-k];
            if (k == 100) begin
                tx_tag   = nx_tag;
                tx_slots = nx_slots;
            end
            @(negedge clk);
        end
        check(sdo_err == 0, "R4/R5", {name, " sdo bit mismatches"}, FRAME_W'(sdo_err), '0);
        check(sync_err == 0, "R2", {name, " sync pattern mismatches"}, FRAME_W'(sync_err), '0);
        check(start_err == 0, "R3", {name, " frame_start mismatches"}, FRAME_W'(start_err), '0);
        check(hold_err == 0, "R6", {name, " rx outputs not held in frame"}, FRAME_W'(hold_err), '0);
        check(frame_done === 1'b1, "R7", {name, " frame_done after last bit"}, FRAME_W'(frame_done), FRAME_W'(1));
        check({rx_tag, rx_slots} === drv_rx, "R6", {name, " captured frame"}, {rx_tag, rx_slots}, drv_rx);
        check(codec_ready === drv_rx[FRAME_W-1], "R8", {name, " codec_ready"},
              FRAME_W'(codec_ready), FRAME_W'(drv_rx[FRAME_W-1]));
        check(frame_start === 1'b1 && sync === 1'b1, "R3", {name, " next frame start"},
              FRAME_W'({frame_start, sync}), FRAME_W'(2'b11));
        prev_rx = drv_rx;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        tx_tag = 16'hA5C3;
        tx_slots = make_slots(1);
        repeat (3) @(negedge clk);
        check({sync, sdo, frame_start, frame_done, codec_ready} === 5'b0, "R1", "control outputs in reset",
              FRAME_W'({sync, sdo, frame_start, frame_done, codec_ready}), '0);
        check({rx_tag, rx_slots} === '0, "R1", "rx outputs in reset", {rx_tag, rx_slots}, '0);
    endtask

    task automatic t_release();
        rst_n = 1'b1;
        @(negedge clk);
        check(frame_start === 1'b1 && sync === 1'b1, "R2", "frame begins on first edge after release",
              FRAME_W'({frame_start, sync}), FRAME_W'(2'b11));
    endtask

    task automatic t_frames();
        logic [FRAME_W-1:0] a, b, c;
        a = {16'hA5C3, make_slots(1)};
        b = {16'h3C01, make_slots(2)};
        c = {16'hFFFF, ~make_slots(6)};
        run_frame(a, {1'b1, 15'h1234, make_slots(3)}, b[FRAME_W-1 -: TAG_W], b[DATA_W-1:0], "frame1");
        run_frame(b, {1'b0, 15'h7FFF, ~make_slots(5)}, c[FRAME_W-1 -: TAG_W], c[DATA_W-1:0], "frame2");
        run_frame(c, {FRAME_W{1'b1}}, a[FRAME_W-1 -: TAG_W], a[DATA_W-1:0], "frame3");
    endtask

    task automatic t_mid_reset();
        logic [FRAME_W-1:0] d;
        d = {16'h8001, make_slots(9)};
        for (int k = 0; k < 50; k++) begin
            sdi = 1'b1;
            @(negedge clk);
        end
        rst_n = 1'b0;
        #1;
        check({sync, sdo, frame_start, frame_done, codec_ready} === 5'b0, "R9", "outputs drop on mid-frame reset",
              FRAME_W'({sync, sdo, frame_start, frame_done, codec_ready}), '0);
        check({rx_tag, rx_slots} === '0, "R1", "rx cleared by reset", {rx_tag, rx_slots}, '0);
        prev_rx = '0;
        repeat (2) @(negedge clk);
        tx_tag = d[FRAME_W-1 -: TAG_W];
        tx_slots = d[DATA_W-1:0];
        rst_n = 1'b1;
        @(negedge clk);
        check(frame_start === 1'b1, "R9", "fresh frame after mid reset", FRAME_W'(frame_start), FRAME_W'(1));
        run_frame(d, {1'b1, 15'h0, {DATA_W{1'b0}}}, 16'h0F0F, make_slots(4), "after_reset");
    endtask

    initial begin
        t_reset_state();
        t_release();
        t_frames();
        t_mid_reset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule